// File: doc/BRIEF.md
# Multi-Channel Edge Timestamp Capture

This block watches the step and direction lines of four stepper motor drivers, eight digital lines in all. Each line passes through a two-flop synchronizer. Every rising or falling edge on a line is stamped with the value of one free-running 16-bit tick counter that all channels share. Because the counter is shared, stamps taken on different channels can be compared directly. The stamps go into a small FIFO for each channel. A downstream framer sends a drain strobe at a regular interval. It must do so at least twice per counter wrap, which is 65536 ticks. On each strobe the block streams out every channel's count of pending stamps, followed by those stamps.

The block also checks the timing rules of the drivers as the edges arrive. A high or low level that lasts less than a minimum width is flagged on its channel. A step rising edge that comes too soon after a direction change is flagged on its motor. The thresholds are parameters given in ticks. The defaults assume a 90 MHz tick: 171 ticks gives about 1.9 us of pulse width, and 59 ticks gives about 650 ns of direction-to-step setup. All flags are sticky and are cleared per channel.

Top module: `edge_stamp_monitor`

## Requirements
- R1: The tick counter is 0 in reset and adds 1 on each clock. An edge is stamped with the counter value held during the clock period in which the input line changed. Lines that change in the same period get identical stamps.
- R2: Rising edges and falling edges are both captured. Each edge produces one FIFO entry.
- R3: Stamps are 16-bit and wrap modulo 65536, so the tick after 0xFFFF stamps as 0x0000.
- R4: A drain strobe seen while the block is idle starts a readout one clock later. The readout sends one word per clock with out_valid_o high. Channels go in order 0 to 7. For each channel there is first a header word (out_hdr_o=1, out_data_o = pending count from 0 to 255). That channel's stamps follow, oldest first, with out_hdr_o=0. out_chan_o gives the channel on every word.
- R5: A drain strobe that arrives during a readout is ignored. No second readout follows.
- R6: An edge that arrives when its FIFO is full (16 entries by default) is dropped, and ovf_o for that channel sets and stays set. Later edges on that channel are dropped until the flag is cleared. After the clear, capture resumes.
- R7: width_viol_o[c] sets when two consecutive edges on line c are less than MIN_PULSE_TICKS apart. A gap of exactly MIN_PULSE_TICKS is not a violation. The first edge after reset is never checked.
- R8: Channel 2m is the step line of motor m, and channel 2m+1 is its direction line. setup_viol_o[m] sets when a step rising edge comes fewer than MIN_SETUP_TICKS after the last direction edge. A direction edge in the same period counts as 0 ticks. Step falling edges are never checked, and neither is a step rise when no direction edge has occurred since reset.
- R9: A pulse on flag_clr_i[c] clears ovf_o[c] and width_viol_o[c], and bit 2m also clears setup_viol_o[m]. The flags read 0 on the next clock.
- R10: After reset all flags and out_valid_o are 0 and every FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock is one tick |
| rst_n | input | 1 | Synchronous active-low reset |
| lines_i | input | 8 | Monitored lines; even bits are step lines, odd bits are direction lines |
| drain_i | input | 1 | Strobe that starts a readout |
| flag_clr_i | input | 8 | Per-channel clear for the sticky flags |
| out_valid_o | output | 1 | Readout word valid |
| out_hdr_o | output | 1 | Word is a channel header holding the count |
| out_chan_o | output | 3 | Channel of the current word |
| out_data_o | output | 16 | Count (header) or timestamp (entry) |
| ovf_o | output | 8 | Sticky FIFO overflow per channel |
| width_viol_o | output | 8 | Sticky minimum-width violation per channel |
| setup_viol_o | output | 4 | Sticky direction-to-step setup violation per motor |

## Verification
A wrong counter offset or a misaligned synchronizer shows up at the first readout after an edge: every stamp is off by a fixed amount from the period in which the line changed. A corrupted FIFO pointer or a wrong level shows up in the next drain as a wrong header count or as stamps out of order. A faulty elapsed-tick counter in the width or setup checker shows up about two clocks after the offending edge, as a flag that is wrong when a gap sits exactly at its threshold or one tick below it.

// File: rtl/edge_mon_pkg.sv
// Shared types for the edge timestamp monitor.
package edge_mon_pkg;
    // Readout sequencer states.
    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_HDR  = 2'd1,
        DR_DATA = 2'd2
    } drain_state_e;

    // Width of the header count field.
    localparam int CNT_W = 8;
endpackage

// File: rtl/line_sync.sv
// line_sync: two-flop synchronizer on one asynchronous line, followed by an
// edge detector. Assumes the line is low while reset is held.
// Edge pulses are combinational from the third flop stage.
module line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o,
    output logic fall_o
);
    logic meta_q, sync_q, prev_q;

    // Synchronize the line and keep the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;
    assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/stamp_fifo.sv
// stamp_fifo: small synchronous FIFO holding timestamps. The head is
// presented combinationally. A push when full or a pop when empty is ignored.
// Push and pop may happen in the same cycle.
module stamp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     din_i,
    input  logic             pop_i,
    output logic [W-1:0]     head_o,
    output logic [LVL_W-1:0] level_o,
    output logic             full_o
);
    logic [W-1:0]     mem_q [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [LVL_W-1:0] lvl_q;
    logic             do_push, do_pop;

    assign full_o  = (lvl_q == LVL_W'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && (lvl_q != '0);
    assign head_o  = mem_q[rd_q];
    assign level_o = lvl_q;

    // Store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= din_i;
    end

    // Advance the pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end
endmodule

// File: rtl/chan_capture.sv
// chan_capture: per-channel capture. It queues a stamp on every edge, keeps
// the sticky overflow flag, and checks the minimum time between consecutive
// edges. Assumes MIN_PULSE >= 1. The elapsed counter saturates, so gaps
// longer than a counter wrap are still judged correctly.
module chan_capture
    import edge_mon_pkg::*;
#(
    parameter int TS_W      = 16,
    parameter int DEPTH     = 16,
    parameter int MIN_PULSE = 171,
    localparam int EL_W  = $clog2(MIN_PULSE + 1),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [TS_W-1:0]  stamp_i,
    input  logic             clr_i,
    input  logic             pop_i,
    output logic [CNT_W-1:0] level_o,
    output logic [TS_W-1:0]  head_o,
    output logic             ovf_o,
    output logic             width_viol_o
);
    localparam logic [EL_W-1:0] MIN_L = EL_W'(MIN_PULSE);

    logic             full, push;
    logic             ovf_q, viol_q, seen_q;
    logic [EL_W-1:0]  elapsed_q;
    logic [LVL_W-1:0] lvl;
    logic             short_gap;

    assign push      = edge_i && !full && !ovf_q;
    assign short_gap = edge_i && seen_q && (elapsed_q < MIN_L);

    stamp_fifo #(.W(TS_W), .DEPTH(DEPTH)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   (stamp_i),
        .pop_i   (pop_i),
        .head_o  (head_o),
        .level_o (lvl),
        .full_o  (full)
    );

    assign level_o = CNT_W'(lvl);

    // Sticky overflow: sets on an edge lost to a full FIFO, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)     ovf_q <= 1'b0;
        else if (clr_i) ovf_q <= 1'b0;
        else if (edge_i && full) ovf_q <= 1'b1;
    end

    // Count ticks since the last edge, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
            seen_q    <= 1'b0;
        end else if (edge_i) begin
            elapsed_q <= EL_W'(1);
            seen_q    <= 1'b1;
        end else if (elapsed_q < MIN_L) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    // Sticky width violation flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         viol_q <= 1'b0;
        else if (clr_i)     viol_q <= 1'b0;
        else if (short_gap) viol_q <= 1'b1;
    end

    assign ovf_o        = ovf_q;
    assign width_viol_o = viol_q;
endmodule

// File: rtl/setup_check.sv
// setup_check: per-motor check of the ticks from the last direction edge to a
// step rising edge. A direction edge in the same cycle counts as zero ticks.
// Assumes MIN_SETUP >= 1.
module setup_check #(
    parameter int MIN_SETUP = 59,
    localparam int EL_W = $clog2(MIN_SETUP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_edge_i,
    input  logic step_rise_i,
    input  logic clr_i,
    output logic viol_o
);
    localparam logic [EL_W-1:0] MIN_L = EL_W'(MIN_SETUP);

    logic [EL_W-1:0] since_q, gap;
    logic            dir_seen_q, hit, viol_q;

    assign gap = dir_edge_i ? '0 : since_q;
    assign hit = step_rise_i && (dir_seen_q || dir_edge_i) && (gap < MIN_L);

    // Ticks since the last direction edge, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q    <= '0;
            dir_seen_q <= 1'b0;
        end else if (dir_edge_i) begin
            since_q    <= EL_W'(1);
            dir_seen_q <= 1'b1;
        end else if (since_q < MIN_L) begin
            since_q <= since_q + 1'b1;
        end
    end

    // Sticky setup violation flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     viol_q <= 1'b0;
        else if (clr_i) viol_q <= 1'b0;
        else if (hit)   viol_q <= 1'b1;
    end

    assign viol_o = viol_q;
endmodule

// File: rtl/drain_sequencer.sv
// drain_sequencer: on a strobe while idle, walks the channels in order. For
// each channel it sends a header with the count taken at that moment, then
// pops exactly that many entries, one word per cycle. Strobes while busy are
// ignored. Entries that arrive after a header wait for the next readout.
module drain_sequencer
    import edge_mon_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int TS_W = 16,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       drain_i,
    input  logic [NCH-1:0][CNT_W-1:0]  lvl_i,
    input  logic [NCH-1:0][TS_W-1:0]   head_i,
    output logic [NCH-1:0]             pop_o,
    output logic                       valid_o,
    output logic                       hdr_o,
    output logic [CH_W-1:0]            chan_o,
    output logic [TS_W-1:0]            data_o
);
    drain_state_e     state_q;
    logic [CH_W-1:0]  ch_q;
    logic [CNT_W-1:0] remain_q;
    logic             last_ch;

    assign last_ch = (ch_q == CH_W'(NCH - 1));

    // Step through the header and entry words of each channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= DR_IDLE;
            ch_q     <= '0;
            remain_q <= '0;
        end else begin
            case (state_q)
                DR_IDLE: begin
                    if (drain_i) begin
                        state_q <= DR_HDR;
                        ch_q    <= '0;
                    end
                end
                DR_HDR: begin
                    remain_q <= lvl_i[ch_q];
                    if (lvl_i[ch_q] != '0) begin
                        state_q <= DR_DATA;
                    end else if (last_ch) begin
                        state_q <= DR_IDLE;
                    end else begin
                        ch_q <= ch_q + 1'b1;
                    end
                end
                DR_DATA: begin
                    remain_q <= remain_q - 1'b1;
                    if (remain_q == CNT_W'(1)) begin
                        if (last_ch) begin
                            state_q <= DR_IDLE;
                        end else begin
                            state_q <= DR_HDR;
                            ch_q    <= ch_q + 1'b1;
                        end
                    end
                end
                default: state_q <= DR_IDLE;
            endcase
        end
    end

    // Pop the current channel on every entry word.
    always_comb begin
        pop_o = '0;
        if (state_q == DR_DATA) pop_o[ch_q] = 1'b1;
    end

    assign valid_o = (state_q != DR_IDLE);
    assign hdr_o   = (state_q == DR_HDR);
    assign chan_o  = ch_q;
    assign data_o  = (state_q == DR_HDR) ? TS_W'(lvl_i[ch_q]) : head_i[ch_q];
endmodule

// File: rtl/edge_stamp_monitor.sv
// edge_stamp_monitor: top level. One shared tick counter stamps the edges of
// every channel. The stamp is the counter value minus the synchronizer
// latency, so it names the period in which the line changed. Channel 2m is the
// step line and channel 2m+1 the direction line of motor m.
module edge_stamp_monitor
    import edge_mon_pkg::*;
#(
    parameter int NUM_MOTORS      = 4,
    parameter int TS_W            = 16,
    parameter int FIFO_DEPTH      = 16,
    parameter int MIN_PULSE_TICKS = 171,
    parameter int MIN_SETUP_TICKS = 59,
    localparam int NCH  = 2 * NUM_MOTORS,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        lines_i,
    input  logic                  drain_i,
    input  logic [NCH-1:0]        flag_clr_i,
    output logic                  out_valid_o,
    output logic                  out_hdr_o,
    output logic [CH_W-1:0]       out_chan_o,
    output logic [TS_W-1:0]       out_data_o,
    output logic [NCH-1:0]        ovf_o,
    output logic [NCH-1:0]        width_viol_o,
    output logic [NUM_MOTORS-1:0] setup_viol_o
);
    localparam int SYNC_LAT = 2;

    logic [TS_W-1:0]                tick_q, stamp;
    logic [NCH-1:0]                 rise, fall, pop;
    logic [NCH-1:0][CNT_W-1:0]      lvl;
    logic [NCH-1:0][TS_W-1:0]       head;

    // Free-running shared tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_q + 1'b1;
    end

    assign stamp = tick_q - TS_W'(SYNC_LAT);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        line_sync sync_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (lines_i[c]),
            .rise_o (rise[c]),
            .fall_o (fall[c])
        );

        chan_capture #(
            .TS_W      (TS_W),
            .DEPTH     (FIFO_DEPTH),
            .MIN_PULSE (MIN_PULSE_TICKS)
        ) cap_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .edge_i       (rise[c] | fall[c]),
            .stamp_i      (stamp),
            .clr_i        (flag_clr_i[c]),
            .pop_i        (pop[c]),
            .level_o      (lvl[c]),
            .head_o       (head[c]),
            .ovf_o        (ovf_o[c]),
            .width_viol_o (width_viol_o[c])
        );
    end

    for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_motor
        setup_check #(.MIN_SETUP(MIN_SETUP_TICKS)) setup_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .dir_edge_i  (rise[2*m+1] | fall[2*m+1]),
            .step_rise_i (rise[2*m]),
            .clr_i       (flag_clr_i[2*m]),
            .viol_o      (setup_viol_o[m])
        );
    end

    drain_sequencer #(.NCH(NCH), .TS_W(TS_W)) drain_i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .drain_i (drain_i),
        .lvl_i   (lvl),
        .head_i  (head),
        .pop_o   (pop),
        .valid_o (out_valid_o),
        .hdr_o   (out_hdr_o),
        .chan_o  (out_chan_o),
        .data_o  (out_data_o)
    );
endmodule

// File: rtl/edge_mon_checker.sv
// edge_mon_checker: port-level properties of edge_stamp_monitor, bound to
// every instance of it.
module edge_mon_checker #(
    parameter int NCH        = 8,
    parameter int NUM_MOTORS = 4,
    parameter int TS_W       = 16,
    parameter int FIFO_DEPTH = 16,
    parameter int CH_W       = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  drain_i,
    input logic [NCH-1:0]        flag_clr_i,
    input logic                  out_valid_o,
    input logic                  out_hdr_o,
    input logic [CH_W-1:0]       out_chan_o,
    input logic [TS_W-1:0]       out_data_o,
    input logic [NCH-1:0]        ovf_o,
    input logic [NCH-1:0]        width_viol_o,
    input logic [NUM_MOTORS-1:0] setup_viol_o
);
    AST_HDR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_hdr_o |-> out_valid_o); // R4

    AST_READOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) |-> ($past(drain_i) && out_hdr_o && out_chan_o == '0)); // R4

    AST_HDR_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_hdr_o) |-> (out_data_o <= TS_W'(FIFO_DEPTH))); // R6

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_o[c] && !flag_clr_i[c]) |=> ovf_o[c]); // R6
        AST_WIDTH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (width_viol_o[c] && !flag_clr_i[c]) |=> width_viol_o[c]); // R7
        AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            flag_clr_i[c] |=> (!ovf_o[c] && !width_viol_o[c])); // R9
    end

    for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_mot
        AST_SETUP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (setup_viol_o[m] && !flag_clr_i[2*m]) |=> setup_viol_o[m]); // R8
        AST_SETUP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            flag_clr_i[2*m] |=> !setup_viol_o[m]); // R9
    end
endmodule

bind edge_stamp_monitor edge_mon_checker #(
    .NCH        (NCH),
    .NUM_MOTORS (NUM_MOTORS),
    .TS_W       (TS_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .CH_W       (CH_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .drain_i      (drain_i),
    .flag_clr_i   (flag_clr_i),
    .out_valid_o  (out_valid_o),
    .out_hdr_o    (out_hdr_o),
    .out_chan_o   (out_chan_o),
    .out_data_o   (out_data_o),
    .ovf_o        (ovf_o),
    .width_viol_o (width_viol_o),
    .setup_viol_o (setup_viol_o)
);

// File: tb/edge_stamp_monitor_tb_top.sv
// Directed bench for edge_stamp_monitor: one task per scenario.
module edge_stamp_monitor_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NCH   = 8;
    localparam int  DEPTH = 16;
    localparam int  MINP  = 171;
    localparam int  MINS  = 59;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  lines = '0;
    logic        drain = 1'b0;
    logic [7:0]  clr = '0;
    logic        out_valid, out_hdr;
    logic [2:0]  out_chan;
    logic [15:0] out_data;
    logic [7:0]  ovf, wviol;
    logic [3:0]  sviol;

    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;
    logic [15:0] tb_cnt;
    logic [15:0] exp_st [NCH][DEPTH];
    int          exp_n  [NCH];
    bit          ovf_m  [NCH];

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference tick counter from R1.
    always @(posedge clk) begin
        if (!rst_n) tb_cnt <= '0;
        else        tb_cnt <= tb_cnt + 16'd1;
    end

    edge_stamp_monitor dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lines_i      (lines),
        .drain_i      (drain),
        .flag_clr_i   (clr),
        .out_valid_o  (out_valid),
        .out_hdr_o    (out_hdr),
        .out_chan_o   (out_chan),
        .out_data_o   (out_data),
        .ovf_o        (ovf),
        .width_viol_o (wviol),
        .setup_viol_o (sviol)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp,
                       input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Flip lines at the current negedge and record the expected stamps.
    task automatic flip(input logic [7:0] mask);
        lines = lines ^ mask;
        for (int c = 0; c < NCH; c++) begin
            if (mask[c]) begin
                if (ovf_m[c] || exp_n[c] == DEPTH) ovf_m[c] = 1'b1;
                else begin
                    exp_st[c][exp_n[c]] = tb_cnt;
                    exp_n[c]++;
                end
            end
        end
    endtask

    task automatic clear(input logic [7:0] mask);
        clr = mask;
        step(1);
        clr = '0;
        for (int c = 0; c < NCH; c++) if (mask[c]) ovf_m[c] = 1'b0;
    endtask

    // Run one readout and compare it word by word; restrobe >= 0 strobes again mid-way.
    task automatic do_drain(input string req, input int restrobe);
        int w;
        w = 0;
        drain = 1'b1;
        step(1);
        for (int c = 0; c < NCH; c++) begin
            drain = (w == restrobe);
            chk(out_valid && out_hdr && out_chan == 3'(c), req, {out_valid, out_hdr}, 3,
                $sformatf("header flags ch%0d", c));
            chk(out_data == 16'(exp_n[c]), req, out_data, exp_n[c],
                $sformatf("count ch%0d", c));
            step(1);
            w++;
            for (int i = 0; i < exp_n[c]; i++) begin
                drain = (w == restrobe);
                chk(out_valid && !out_hdr && out_chan == 3'(c), req, {out_valid, out_hdr},
                    2, $sformatf("entry flags ch%0d", c));
                chk(out_data == exp_st[c][i], req, out_data, exp_st[c][i],
                    $sformatf("stamp ch%0d #%0d", c, i));
                step(1);
                w++;
            end
            exp_n[c] = 0;
        end
        drain = 1'b0;
        for (int k = 0; k < ((restrobe >= 0) ? 5 : 1); k++) begin
            chk(!out_valid, (restrobe >= 0) ? "R5" : req, out_valid, 0, "idle after readout");
            step(1);
        end
    endtask

    task automatic t_reset();
        chk(ovf == 0 && wviol == 0 && sviol == 0, "R10", {ovf, wviol, 4'(sviol)}, 0, "flags");
        chk(!out_valid, "R10", out_valid, 0, "out_valid");
        do_drain("R10", -1);
    endtask

    task automatic t_basic();
        step(20);
        flip(8'h01);
        step(37);
        flip(8'h08);
        step(200);
        flip(8'h01);
        step(4);
        do_drain("R1", -1);
    endtask

    task automatic t_simul();
        step(250);
        flip(8'h22);
        step(4);
        do_drain("R1", -1);
    endtask

    task automatic t_width();
        clear(8'hFF);
        step(300);
        flip(8'h40);
        step(MINP - 1);
        flip(8'h40);
        step(4);
        chk(wviol[6] == 1'b1, "R7", wviol[6], 1, "gap one below threshold");
        clear(8'h40);
        chk(wviol[6] == 1'b0, "R9", wviol[6], 0, "width flag cleared");
        step(300);
        flip(8'h40);
        step(MINP);
        flip(8'h40);
        step(4);
        chk(wviol[6] == 1'b0, "R7", wviol[6], 0, "gap exactly at threshold");
        do_drain("R2", -1);
    endtask

    task automatic t_setup();
        clear(8'hFF);
        step(300);
        flip(8'h02);
        step(MINS - 1);
        flip(8'h01);
        step(4);
        chk(sviol[0] == 1'b1, "R8", sviol[0], 1, "setup one below threshold");
        step(300);
        flip(8'h01);
        clear(8'h01);
        chk(sviol[0] == 1'b0, "R9", sviol[0], 0, "setup flag cleared");
        step(300);
        flip(8'h02);
        step(MINS);
        flip(8'h01);
        step(4);
        chk(sviol[0] == 1'b0, "R8", sviol[0], 0, "setup exactly at threshold");
        step(300);
        flip(8'h01);
        step(300);
        flip(8'h03);
        step(4);
        chk(sviol[0] == 1'b1, "R8", sviol[0], 1, "same-cycle dir and step");
        clear(8'h01);
        step(300);
        flip(8'h02);
        step(5);
        flip(8'h01);
        step(4);
        chk(sviol[0] == 1'b0, "R8", sviol[0], 0, "step fall near dir edge");
        chk(wviol[1:0] == 2'b00, "R7", wviol[1:0], 0, "long gaps on motor 0");
        do_drain("R2", -1);
    endtask

    task automatic t_overflow();
        clear(8'hFF);
        for (int i = 0; i < DEPTH; i++) begin
            flip(8'h80);
            step(3);
        end
        step(2);
        chk(ovf[7] == 1'b0, "R6", ovf[7], 0, "exactly full");
        flip(8'h80);
        step(4);
        chk(ovf[7] == 1'b1, "R6", ovf[7], 1, "edge into full FIFO");
        do_drain("R6", -1);
        flip(8'h80);
        step(4);
        chk(ovf[7] == 1'b1, "R6", ovf[7], 1, "flag held");
        do_drain("R6", -1);
        clear(8'h80);
        chk(ovf[7] == 1'b0, "R9", ovf[7], 0, "overflow cleared");
        step(2);
        flip(8'h80);
        step(4);
        do_drain("R6", -1);
    endtask

    task automatic t_busy();
        step(10);
        flip(8'h01);
        step(200);
        flip(8'h01);
        step(200);
        flip(8'h01);
        step(4);
        do_drain("R4", 2);
        flip(8'h01);
        step(4);
    endtask

    task automatic t_wrap();
        while (tb_cnt != 16'hFFFE) step(1);
        flip(8'h10);
        step(3);
        flip(8'h10);
        step(4);
        do_drain("R3", -1);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            exp_n[c] = 0;
            ovf_m[c] = 1'b0;
        end
        step(5);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_basic();
        t_simul();
        t_width();
        t_setup();
        t_overflow();
        t_busy();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule